// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM out of reset and keeps its contents valid. Once reset is released it stays silent for a start-up pause of at least 100 µs. It then runs a burst of eight refresh cycles. Only after that burst does it raise `ready_o`, which lets the rest of the memory controller start traffic. In normal operation it asks an access arbiter for the bus once per row interval, and each time it is granted it drives one refresh cycle on the RAS#, CAS# and WE# strobes.

Each refresh cycle is one of two kinds. In CAS-before-RAS mode the device advances its own row pointer, and WE# is held high. In RAS-only mode the block supplies the row from an internal counter, which wraps at the configured row count. The per-row interval is worked out at elaboration time from the clock frequency, the row count and the refresh period. The period is 32 ms or 64 ms in standard mode, and 128 ms for both row counts in extended mode. The request goes up a set number of cycles before the deadline, so that an access already in progress can finish first.

If the arbiter does not grant before the deadline, the block sets a sticky missed flag and drops `ready_o`. It then repeats the full eight-cycle wake-up burst before returning to normal service.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ras_no` and `cas_no` stay high and `ref_req_o` stays low for PAUSE_CYC = CLK_HZ*PAUSE_US/10^6 cycles. The first request is raised in the cycle after that, so with an immediate grant the first strobe falls on clock edge PAUSE_CYC+1 after reset release.
- R2: After the pause, exactly eight refresh cycles (eight falling edges of `ras_no`) occur before `ready_o` goes high. `ready_o` is low during the pause and during the burst.
- R3: When `cbr_mode_i`=1, `cas_no` falls T_CSR cycles before `ras_no` falls. When `cbr_mode_i`=0 (RAS-only), `cas_no` stays high for the whole cycle. `we_no` is high at all times.
- R4: The per-row interval is INT = floor(CLK_HZ*PERIOD_MS/(1000*ROWS)). `rows_sel_i`=0 selects ROWS=2^(ROW_W-1) and `rows_sel_i`=1 selects ROWS=2^ROW_W. PERIOD_MS is 128 when EXTENDED=1. When EXTENDED=0 it is 32 for the smaller row count and 64 for the larger.
- R5: In service, `ref_req_o` rises once fewer than MARGIN cycles remain before the deadline. If the arbiter grants as soon as it sees the request, successive refresh starts are INT-MARGIN+1 cycles apart.
- R6: If no refresh starts within INT cycles of the previous start, `missed_o` rises on edge start+INT and `ready_o` drops in the same cycle. No strobe is driven without a grant. Eight wake-up cycles then repeat, after which `ready_o` returns high and `missed_o` clears.
- R7: In RAS-only mode, `row_o` presents 0 for the first refresh after reset and advances by one after each RAS-only cycle. It wraps to 0 after ROWS-1.
- R8: In reset, `ready_o`, `missed_o`, `ref_req_o` and `ref_active_o` are low and all strobes are high. Within one cycle, `ras_no` stays low for T_RAS cycles and is followed by T_RP precharge cycles. No request is raised while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rows_sel_i | input | 1 | Row count: 0 = 2^(ROW_W-1), 1 = 2^ROW_W |
| cbr_mode_i | input | 1 | 1 = CAS-before-RAS refresh, 0 = RAS-only refresh |
| ref_gnt_i | input | 1 | Arbiter grant; a cycle starts when it is high together with the request |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ready_o | output | 1 | Wake-up done; normal traffic allowed |
| missed_o | output | 1 | Sticky missed-deadline flag, held until the repeated wake-up completes |
| ref_active_o | output | 1 | The block owns the strobes (refresh cycle in progress) |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, held high |
| row_o | output | ROW_W | Row address for RAS-only refresh |

## Verification
The assertions assume three things about the inputs. First, `rows_sel_i` and `cbr_mode_i` change only while reset is held. Second, a grant counts only while the request is high. Third, INT-MARGIN is longer than one refresh cycle, so a reloaded deadline can never land inside a running cycle. The bench keeps to these assumptions. It changes the configuration only under reset, and it forms the grant as its own enable ANDed with the request. Its clock-frequency parameter makes the intervals short enough that every row of both row counts can be walked through.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } sched_st_e;

  typedef enum logic [1:0] {
    CY_IDLE = 2'd0,
    CY_CSR  = 2'd1,
    CY_ACT  = 2'd2,
    CY_PRE  = 2'd3
  } cyc_st_e;

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  // saturating down counter; shared by pause and row deadline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= RST_VAL;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dram_ref_cycle.sv
module dram_ref_cycle
  import dram_refresh_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_RAS = 4,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cbr_i,
  output logic busy_o,
  output logic done_o,
  output logic cbr_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no
);

  localparam int unsigned T_MAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                                  : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int unsigned TW = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] LD_CSR = TW'(T_CSR - 1);
  localparam logic [TW-1:0] LD_RAS = TW'(T_RAS - 1);
  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 1);

  cyc_st_e        st_q;
  logic [TW-1:0]  tcnt_q;
  logic           cbr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CY_IDLE;
      tcnt_q <= '0;
      cbr_q  <= 1'b0;
    end else begin
      unique case (st_q)
        CY_IDLE: if (start_i) begin
          cbr_q <= cbr_i;
          if (cbr_i) begin
            st_q   <= CY_CSR;
            tcnt_q <= LD_CSR;
          end else begin
            st_q   <= CY_ACT;
            tcnt_q <= LD_RAS;
          end
        end
        CY_CSR: if (tcnt_q == '0) begin
          st_q   <= CY_ACT;
          tcnt_q <= LD_RAS;
        end else tcnt_q <= tcnt_q - 1'b1;
        CY_ACT: if (tcnt_q == '0) begin
          st_q   <= CY_PRE;
          tcnt_q <= LD_RP;
        end else tcnt_q <= tcnt_q - 1'b1;
        CY_PRE: if (tcnt_q == '0) st_q <= CY_IDLE;
                else tcnt_q <= tcnt_q - 1'b1;
        default: st_q <= CY_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != CY_IDLE);
  assign done_o = (st_q == CY_PRE) && (tcnt_q == '0);
  assign cbr_o  = cbr_q;
  assign ras_no = (st_q != CY_ACT);
  assign cas_no = !(cbr_q && ((st_q == CY_CSR) || (st_q == CY_ACT)));
  assign we_no  = 1'b1;

  // R3: in CBR mode the row strobe only falls after the column strobe is already low
  p_cbr_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && cbr_q) |-> $past(!cas_no));

  // R8: the scheduler never starts a cycle on top of a running one
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);

  // R8: a finished cycle releases the strobes on the next edge
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (ras_no && cas_no));

endmodule

// File: rtl/dram_row_ctr.sv
module dram_row_ctr #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             hi_rows_i,
  output logic [ROW_W-1:0] row_o
);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_row;

  assign last_row = hi_rows_i ? {ROW_W{1'b1}} : {1'b0, {(ROW_W-1){1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      row_q <= '0;
    else if (inc_i)   row_q <= (row_q == last_row) ? '0 : row_q + 1'b1;
  end

  assign row_o = row_q;

  // R7: the counter returns to row zero after the last row
  p_row_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && (row_q == last_row) && $stable(hi_rows_i)) |=> (row_q == '0));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned PAUSE_US    = 100,
  parameter bit          EXTENDED    = 1'b1,
  parameter int unsigned ROW_W       = 12,
  parameter int unsigned MARGIN      = 8,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned T_CSR       = 1,
  parameter int unsigned T_RAS       = 4,
  parameter int unsigned T_RP        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rows_sel_i,
  input  logic             cbr_mode_i,
  input  logic             ref_gnt_i,
  output logic             ref_req_o,
  output logic             ready_o,
  output logic             missed_o,
  output logic             ref_active_o,
  output logic             ras_no,
  output logic             cas_no,
  output logic             we_no,
  output logic [ROW_W-1:0] row_o
);

  localparam longint unsigned PER_LO_MS = EXTENDED ? 128 : 32;
  localparam longint unsigned PER_HI_MS = EXTENDED ? 128 : 64;
  localparam longint unsigned ROWS_LO   = 64'd1 << (ROW_W - 1);
  localparam longint unsigned ROWS_HI   = 64'd1 << ROW_W;
  localparam longint unsigned PAUSE_CYC = (longint'(CLK_HZ) * PAUSE_US) / 1_000_000;
  localparam longint unsigned INT_LO    = (longint'(CLK_HZ) * PER_LO_MS) / (1000 * ROWS_LO);
  localparam longint unsigned INT_HI    = (longint'(CLK_HZ) * PER_HI_MS) / (1000 * ROWS_HI);
  localparam longint unsigned INT_MAX   = (INT_LO > INT_HI) ? INT_LO : INT_HI;
  localparam longint unsigned CNT_MAX   = (PAUSE_CYC > INT_MAX) ? PAUSE_CYC : INT_MAX;
  localparam int unsigned     CNT_W     = $clog2(CNT_MAX + 1);
  localparam int unsigned     WK_W      = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAUSE_LD  = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] INT_LO_LD = CNT_W'(INT_LO - 1);
  localparam logic [CNT_W-1:0] INT_HI_LD = CNT_W'(INT_HI - 1);
  localparam logic [CNT_W-1:0] MARGIN_C  = CNT_W'(MARGIN);
  localparam logic [WK_W-1:0]  WAKE_LAST = WK_W'(WAKE_CYCLES - 1);

  sched_st_e        st_q;
  logic [WK_W-1:0]  wake_q;
  logic             missed_q;

  logic             start;
  logic             cyc_busy, cyc_done, cyc_cbr;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_cnt, t_ld_val;
  logic             wake_last;

  assign start     = ref_req_o && ref_gnt_i;
  assign wake_last = (st_q == ST_WAKE) && cyc_done && (wake_q == WAKE_LAST);
  assign t_load    = wake_last || ((st_q == ST_RUN) && start);
  assign t_ld_val  = rows_sel_i ? INT_HI_LD : INT_LO_LD;

  dram_ref_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PAUSE_LD)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (t_load),
    .load_val_i(t_ld_val),
    .cnt_o     (t_cnt),
    .zero_o    (t_zero)
  );

  dram_ref_cycle #(
    .T_CSR(T_CSR),
    .T_RAS(T_RAS),
    .T_RP (T_RP)
  ) u_cycle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .cbr_i  (cbr_mode_i),
    .busy_o (cyc_busy),
    .done_o (cyc_done),
    .cbr_o  (cyc_cbr),
    .ras_no (ras_no),
    .cas_no (cas_no),
    .we_no  (we_no)
  );

  dram_row_ctr #(
    .ROW_W(ROW_W)
  ) u_rows (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (cyc_done && !cyc_cbr),
    .hi_rows_i(rows_sel_i),
    .row_o    (row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_PAUSE;
      wake_q   <= '0;
      missed_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_PAUSE: if (t_zero) st_q <= ST_WAKE;
        ST_WAKE: if (cyc_done) begin
          if (wake_q == WAKE_LAST) begin
            st_q     <= ST_RUN;
            wake_q   <= '0;
            missed_q <= 1'b0;
          end else begin
            wake_q <= wake_q + 1'b1;
          end
        end
        ST_RUN: if (!start && t_zero) begin
          st_q     <= ST_WAKE;
          missed_q <= 1'b1;
        end
        default: st_q <= ST_PAUSE;
      endcase
    end
  end

  // request early by MARGIN so an in-flight access can complete
  assign ref_req_o    = !cyc_busy &&
                        ((st_q == ST_WAKE) || ((st_q == ST_RUN) && (t_cnt < MARGIN_C)));
  assign ready_o      = (st_q == ST_RUN);
  assign missed_o     = missed_q;
  assign ref_active_o = cyc_busy;

  // R1: strobes idle and no request during the start-up pause
  p_quiet_pause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE) |-> (ras_no && cas_no && !ref_req_o));

  // R2: ready only after the last wake-up cycle completes
  p_ready_after_wake_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(cyc_done) && ($past(wake_q) == WAKE_LAST)));

  // R6: an expired deadline without a grant flags the miss on the next edge
  p_deadline_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RUN) && t_zero && !start) |=> (missed_o && !ready_o));

  // R6: the miss flag clears only together with ready returning
  p_miss_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(missed_o) |-> $rose(ready_o));

  // R8: strobes are driven only while the block owns them
  p_strobe_owner_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_no || !cas_no) |-> ref_active_o);

endmodule

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;

  localparam int CLK_P    = 10;
  localparam int CLK_HZ   = 1_000_000;
  localparam int PAUSE_US = 100;
  localparam int MARGIN   = 4;
  localparam int T_CSR    = 1;
  localparam int T_RAS    = 3;
  localparam int T_RP     = 2;
  localparam int ROW_W    = 12;
  localparam int PAUSE_CYC = CLK_HZ / 1_000_000 * PAUSE_US;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // extended-period instance
  logic rst_n = 1'b0, sel = 1'b0, cbr = 1'b0, gen = 1'b1;
  logic req, gnt, ready, missed, act, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] row;
  assign gnt = gen & req;

  dram_refresh_sched #(
    .CLK_HZ(CLK_HZ), .PAUSE_US(PAUSE_US), .EXTENDED(1'b1), .ROW_W(ROW_W),
    .MARGIN(MARGIN), .WAKE_CYCLES(8), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rows_sel_i(sel), .cbr_mode_i(cbr),
    .ref_gnt_i(gnt), .ref_req_o(req), .ready_o(ready), .missed_o(missed),
    .ref_active_o(act), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .row_o(row)
  );

  // standard-period instance, RAS-only, always granted
  logic rst2_n = 1'b0, sel2 = 1'b0;
  logic req2, ready2, missed2, act2, ras2_n, cas2_n, we2_n;
  logic [ROW_W-1:0] row2;

  dram_refresh_sched #(
    .CLK_HZ(CLK_HZ), .PAUSE_US(PAUSE_US), .EXTENDED(1'b0), .ROW_W(ROW_W),
    .MARGIN(MARGIN), .WAKE_CYCLES(8), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) uut_std (
    .clk_i(clk), .rst_ni(rst2_n), .rows_sel_i(sel2), .cbr_mode_i(1'b0),
    .ref_gnt_i(req2), .ref_req_o(req2), .ready_o(ready2), .missed_o(missed2),
    .ref_active_o(act2), .ras_no(ras2_n), .cas_no(cas2_n), .we_no(we2_n), .row_o(row2)
  );

  // edges since the extended instance left reset
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int exp_int(input bit ext, input bit hi);
    int rows, per;
    rows = hi ? (1 << ROW_W) : (1 << (ROW_W - 1));
    per  = ext ? 128 : (hi ? 64 : 32);
    return int'((longint'(CLK_HZ) * per) / (longint'(1000) * rows));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic run_cfg(input bit m_cbr, input bit m_sel, input int ival);
    int t_first, falls, n, rowerr, webad, casbad, ordbad, t_cas;
    int times[4];
    bit prev_ras, prev_cas;
    cbr = m_cbr; sel = m_sel; gen = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!ready && !missed && !req && !act && ras_n && cas_n && we_n,
        "R8 reset state", {ready, missed, req, act, ras_n, cas_n, we_n}, 7'b0000111);
    rst_n = 1'b1;
    do @(negedge clk); while (ras_n && cas_n);
    t_first = cyc;
    chk(t_first == PAUSE_CYC + 1, "R1 first strobe edge", t_first, PAUSE_CYC + 1);
    chk(m_cbr ? (!cas_n && ras_n) : (cas_n && !ras_n), "R3 first strobe kind",
        {ras_n, cas_n}, m_cbr ? 2'b10 : 2'b01);
    falls = 0; rowerr = 0; webad = 0; casbad = 0; ordbad = 0; n = 0;
    prev_ras = 1'b1; prev_cas = 1'b1; t_cas = 0;
    while (n < 4) begin
      if (prev_cas && !cas_n) t_cas = cyc;
      if (prev_ras && !ras_n) begin
        if (!m_cbr && (int'(row) != falls)) rowerr++;
        if (m_cbr && (cas_n || (cyc - t_cas != T_CSR))) ordbad++;
        if (ready) begin
          times[n] = cyc;
          n++;
        end
        falls++;
      end
      if (!we_n) webad++;
      if (!m_cbr && !cas_n) casbad++;
      if (ready && falls < 9 && n == 0 && falls != 8) begin
        chk(1'b0, "R2 wake-up count", falls, 8);
        falls = 8;
      end
      prev_ras = ras_n; prev_cas = cas_n;
      @(negedge clk);
    end
    // R2: exactly eight wake-up cycles preceded ready
    chk(falls == 12, "R2 eight wake cycles then service", falls - 4, 8);
    for (int i = 1; i < 4; i++)
      chk(times[i] - times[i-1] == ival - MARGIN + 1, "R4 R5 refresh spacing",
          times[i] - times[i-1], ival - MARGIN + 1);
    chk(webad == 0, "R3 write enable high", webad, 0);
    if (m_cbr) chk(ordbad == 0, "R3 cas leads ras", ordbad, 0);
    else begin
      chk(casbad == 0, "R3 cas idle in row-only", casbad, 0);
      chk(rowerr == 0, "R7 row sequence", rowerr, 0);
    end
  endtask

  task automatic run_miss(input int ival);
    int t0, t1, stray, falls;
    bit prev_ras;
    prev_ras = ras_n;
    while (!(prev_ras && !ras_n)) begin
      prev_ras = ras_n;
      @(negedge clk);
    end
    t0 = cyc;
    gen = 1'b0;
    stray = 0;
    prev_ras = ras_n;
    while (!missed && (cyc - t0 < 4 * ival)) begin
      @(negedge clk);
      if (prev_ras && !ras_n) stray++;
      prev_ras = ras_n;
    end
    t1 = cyc;
    chk(t1 - t0 == ival, "R6 miss flag timing", t1 - t0, ival);
    chk(!ready, "R6 ready dropped on miss", ready, 0);
    chk(stray == 0, "R6 no strobe without grant", stray, 0);
    gen = 1'b1;
    falls = 0;
    prev_ras = ras_n;
    while (!ready) begin
      @(negedge clk);
      if (prev_ras && !ras_n) falls++;
      prev_ras = ras_n;
    end
    chk(falls == 8, "R6 wake burst repeated", falls, 8);
    chk(!missed, "R6 miss flag cleared", missed, 0);
  endtask

  task automatic run_wrap(input bit m_sel);
    int rows, k, rowerr, t20;
    bit prev_ras;
    rows = m_sel ? (1 << ROW_W) : (1 << (ROW_W - 1));
    sel2 = m_sel; rst2_n = 1'b0;
    repeat (3) @(negedge clk);
    rst2_n = 1'b1;
    k = 0; rowerr = 0; t20 = 0; prev_ras = 1'b1;
    while (k <= rows) begin
      @(negedge clk);
      if (prev_ras && !ras2_n) begin
        if (int'(row2) != (k % rows)) rowerr++;
        if (k == rows) chk(row2 == '0, "R7 row wraps to zero", row2, 0);
        if (k == 20) t20 = checks;
        if (k == 20) t20 = 0;
        k++;
      end
      if (!ras2_n || !cas2_n || ready2) t20++;
      prev_ras = ras2_n;
    end
    chk(rowerr == 0, "R7 row sequence full sweep", rowerr, 0);
  endtask

  task automatic run_std_spacing(input bit m_sel);
    int k, ta, ival;
    bit prev_ras;
    ival = exp_int(1'b0, m_sel);
    sel2 = m_sel; rst2_n = 1'b0;
    repeat (3) @(negedge clk);
    rst2_n = 1'b1;
    k = 0; ta = 0; prev_ras = 1'b1;
    while (k < 22) begin
      @(negedge clk);
      if (prev_ras && !ras2_n) begin
        if (k == 20) ta = $time / CLK_P;
        if (k == 21) chk(($time / CLK_P) - ta == ival - MARGIN + 1, "R4 standard period spacing",
                         ($time / CLK_P) - ta, ival - MARGIN + 1);
        k++;
      end
      prev_ras = ras2_n;
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190_000, 0);
    finish_run();
  end

  initial begin
    // CBR, larger row count, extended period
    run_cfg(1'b1, 1'b1, exp_int(1'b1, 1'b1));
    // RAS-only, smaller row count, extended period
    run_cfg(1'b0, 1'b0, exp_int(1'b1, 1'b0));
    run_miss(exp_int(1'b1, 1'b0));
    // RAS-only, larger row count, miss path again
    run_cfg(1'b0, 1'b1, exp_int(1'b1, 1'b1));
    run_miss(exp_int(1'b1, 1'b1));
    // standard period: spacing and full row sweeps
    run_std_spacing(1'b0);
    run_std_spacing(1'b1);
    run_wrap(1'b0);
    run_wrap(1'b1);
    finish_run();
  end

endmodule